// File: doc/BRIEF.md
# Multiframe Clock Alignment and Lane Alignment Start Control

This block handles transmit-side timing for a deterministic-latency serial converter link. It runs in the frame clock domain and keeps a local multiframe counter that steps through the frames of each multiframe. The counter is realigned to the rising edge of a shared SYSREF reference. Because every converter on a board receives the same SYSREF, counters in separate devices produce their multiframe boundaries on the same clock edge.

The block also watches the active-low synchronization request from the receiver. While the request is held low, the block reports the code-group-sync phase. After the request is released, the block lets the next multiframe boundary pass. It then waits one whole extra multiframe and pulses `ila_start` on the boundary after that. The alignment sequence lasts a fixed number of multiframes. A `ila_done` pulse on the boundary that closes it marks the start of user data.

The multiframe length is set at run time through `frames_m1`, which holds K-1. No receive-buffer release offset is added.

Top module: `lmfc_ila_ctrl`

## Requirements
- R1: After reset, `frame_idx` is 0, `cgs_phase` is 1 and `misalign` is 0. Between realignments, `frame_idx` counts 0, 1, … K-1, where K-1 is the value of `frames_m1`, and then returns to 0. `lmfc_tick` is 1 exactly in the cycles where `frame_idx` is 0.
- R2: SYSREF is registered twice and then edge-detected. `frame_idx` reads 0 after the third rising clock edge, counting from the first edge that samples `sysref` high after a low sample.
- R3: The first SYSREF rising edge after reset always realigns the counter and leaves `misalign` at 0. A later edge whose realignment coincides with the natural wrap (`frame_idx` equal to K-1 at the realigning edge) changes neither the count sequence nor `misalign`.
- R4: A later SYSREF edge that lands off the boundary forces `frame_idx` to 0 and sets `misalign`. The flag stays at 1 until reset.
- R5: `cgs_phase` is 1 in the cycle after any clock edge that samples `sync_n` low, and it stays 1 while `sync_n` stays low.
- R6: Take the release cycle to be the first cycle with `sync_n` high after the code-group-sync phase, and let p be the `frame_idx` of that cycle. `ila_start` then pulses for one cycle exactly 2K-p cycles later, on a boundary where `lmfc_tick` is 1.
- R7: A release that falls in the boundary cycle itself (p = 0) does not count that boundary, so the delay is the full 2K. All release offsets 0 to K-1 within one multiframe reach the same ILA boundary (p plus the delay equals 2K).
- R8: `ila_done` pulses for one cycle on the fourth boundary after `ila_start`, which is 4K cycles later. It does not pulse again until a new release.
- R9: Driving `sync_n` low during the hold, the alignment sequence or user data suppresses any pending `ila_start` or `ila_done` pulse. A new release then follows R6 again.
- R10: The behaviour above holds for other multiframe lengths, for example K = 8 with `frames_m1` equal to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sysref | input | 1 | Shared multiframe reference |
| sync_n | input | 1 | Active-low synchronization request from the receiver |
| frames_m1 | input | $clog2(K_MAX) | Frames per multiframe minus one |
| lmfc_tick | output | 1 | High in the first frame of each multiframe |
| frame_idx | output | $clog2(K_MAX) | Current frame index within the multiframe |
| cgs_phase | output | 1 | Code-group-sync phase is active |
| ila_start | output | 1 | First alignment multiframe begins in this cycle |
| ila_done | output | 1 | User data begins in this cycle |
| misalign | output | 1 | Sticky flag: a later SYSREF edge landed off the boundary |

## Verification
These outputs come from registers and change one rising edge after the cause: `frame_idx`, `misalign` and `cgs_phase`. A SYSREF change reaches the counter three edges after it is first sampled. `ila_start` and `ila_done` are decoded from state, so they appear in the boundary cycle itself. The bench drives inputs just after the falling edge and advances its reference model on the rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. The directed checks count falling edges from the release cycle and compare the count with 2K-p and 4K. They also check `frame_idx` at the third falling edge after a SYSREF pulse.

// File: rtl/lmfc_ila_ctrl.sv
module lmfc_ila_ctrl #(
  parameter int K_MAX  = 32,
  parameter int ILA_MF = 4,
  localparam int CW = $clog2(K_MAX),
  localparam int IW = (ILA_MF > 1) ? $clog2(ILA_MF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sysref,
  input  logic          sync_n,
  input  logic [CW-1:0] frames_m1,
  output logic          lmfc_tick,
  output logic [CW-1:0] frame_idx,
  output logic          cgs_phase,
  output logic          ila_start,
  output logic          ila_done,
  output logic          misalign
);

  typedef enum logic [1:0] {ST_CGS, ST_HOLD, ST_ILA, ST_DATA} st_t;

  logic [2:0]    sr_q;
  logic          sr_edge, at_wrap, aligned;
  logic [CW-1:0] cnt;
  st_t           st;
  logic          seen;
  logic [IW-1:0] ila_n;
  logic          last_ila;

  assign sr_edge  = sr_q[1] & ~sr_q[2];
  assign at_wrap  = cnt >= frames_m1;
  assign last_ila = ila_n == IW'(ILA_MF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      cnt      <= '0;
      aligned  <= 1'b0;
      misalign <= 1'b0;
    end else begin
      sr_q     <= {sr_q[1:0], sysref};
      cnt      <= (sr_edge | at_wrap) ? '0 : cnt + 1'b1;
      aligned  <= aligned | sr_edge;
      misalign <= misalign | (sr_edge & aligned & ~at_wrap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_CGS;
      seen  <= 1'b0;
      ila_n <= '0;
    end else if (!sync_n) begin
      st    <= ST_CGS;
      seen  <= 1'b0;
      ila_n <= '0;
    end else begin
      case (st)
        ST_CGS: begin
          st   <= ST_HOLD;
          seen <= 1'b0;
        end
        ST_HOLD: if (lmfc_tick) begin
          if (seen) begin
            st    <= ST_ILA;
            ila_n <= '0;
          end else begin
            seen <= 1'b1;
          end
        end
        ST_ILA: if (lmfc_tick) begin
          if (last_ila) st <= ST_DATA;
          else          ila_n <= ila_n + 1'b1;
        end
        default: st <= ST_DATA;
      endcase
    end
  end

  assign frame_idx = cnt;
  assign lmfc_tick = cnt == '0;
  assign cgs_phase = st == ST_CGS;
  assign ila_start = sync_n & (st == ST_HOLD) & seen & lmfc_tick;
  assign ila_done  = sync_n & (st == ST_ILA) & last_ila & lmfc_tick;

endmodule

module lmfc_ila_ctrl_chk #(
  parameter int K_MAX = 32,
  localparam int CW = $clog2(K_MAX)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_n,
  input logic [CW-1:0] frames_m1,
  input logic          lmfc_tick,
  input logic [CW-1:0] frame_idx,
  input logic          cgs_phase,
  input logic          ila_start,
  input logic          ila_done,
  input logic          misalign,
  input logic          sr_edge,
  input logic          aligned
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_edge && frame_idx < frames_m1) |=> frame_idx == CW'($past(frame_idx) + 1'b1)); // R1

  AST_FIRST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_edge && !aligned) |=> (frame_idx == '0 && !misalign)); // R3

  AST_ONBOUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_edge && frame_idx >= frames_m1) |=> (frame_idx == '0 && $stable(misalign))); // R3

  AST_OFFBOUND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_edge && aligned && frame_idx < frames_m1) |=> (frame_idx == '0 && misalign)); // R4

  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign); // R4

  AST_CGS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> cgs_phase); // R5

  AST_START_ON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ila_start |-> (lmfc_tick && !cgs_phase && sync_n)); // R6

  AST_DONE_ON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ila_done |-> (lmfc_tick && !ila_start && sync_n)); // R8

endmodule

bind lmfc_ila_ctrl lmfc_ila_ctrl_chk #(.K_MAX(K_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .frames_m1(frames_m1),
  .lmfc_tick(lmfc_tick), .frame_idx(frame_idx), .cgs_phase(cgs_phase),
  .ila_start(ila_start), .ila_done(ila_done), .misalign(misalign),
  .sr_edge(sr_edge), .aligned(aligned)
);

// File: tb/test_lmfc_ila_ctrl.sv
module test_lmfc_ila_ctrl;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sysref = 1'b0, sync_n = 1'b0;
  logic [CW-1:0] frames_m1 = 5'd15;
  logic lmfc_tick, cgs_phase, ila_start, ila_done, misalign;
  logic [CW-1:0] frame_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  lmfc_ila_ctrl i_lmfc_ila_ctrl (
    .clk(clk), .rst_n(rst_n), .sysref(sysref), .sync_n(sync_n),
    .frames_m1(frames_m1), .lmfc_tick(lmfc_tick), .frame_idx(frame_idx),
    .cgs_phase(cgs_phase), .ila_start(ila_start), .ila_done(ila_done),
    .misalign(misalign)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: frame count, sysref history, phase, hold, ila count
  int hist[3];
  int m_cnt, m_al, m_mis, m_st, m_seen, m_in;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_al = 0; m_mis = 0; m_st = 0; m_seen = 0; m_in = 0;
    end else begin
      int km1, e, wr, tk;
      km1 = int'(frames_m1);
      e  = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
      wr = (m_cnt >= km1) ? 1 : 0;
      tk = (m_cnt == 0) ? 1 : 0;
      if (!sync_n) begin
        m_st = 0; m_seen = 0; m_in = 0;
      end else if (m_st == 0) begin
        m_st = 1; m_seen = 0;
      end else if (m_st == 1 && tk == 1) begin
        if (m_seen == 1) begin m_st = 2; m_in = 0; end
        else m_seen = 1;
      end else if (m_st == 2 && tk == 1) begin
        if (m_in == 3) m_st = 3;
        else m_in++;
      end
      if (e == 1 && m_al == 1 && wr == 0) m_mis = 1;
      m_cnt = (e == 1 || wr == 1) ? 0 : m_cnt + 1;
      if (e == 1) m_al = 1;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = int'(sysref);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 frame_idx", int'(frame_idx), m_cnt);
      chk("R1 lmfc_tick", int'(lmfc_tick), (m_cnt == 0) ? 1 : 0);
      chk("R5 cgs_phase", int'(cgs_phase), (m_st == 0) ? 1 : 0);
      chk("R6 ila_start", int'(ila_start),
          (sync_n && m_st == 1 && m_seen == 1 && m_cnt == 0) ? 1 : 0);
      chk("R8 ila_done", int'(ila_done),
          (sync_n && m_st == 2 && m_in == 3 && m_cnt == 0) ? 1 : 0);
      chk("R4 misalign", int'(misalign), m_mis);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_frame(int p);
    @(negedge clk);
    while (m_cnt != p) @(negedge clk);
    #1;
  endtask

  task automatic sysref_pulse_at(int p);
    wait_frame(p);
    sysref = 1'b1;
    cyc(1);
    sysref = 1'b0;
  endtask

  task automatic do_reset(int km1);
    rst_n = 1'b0; sync_n = 1'b0; sysref = 1'b0;
    frames_m1 = CW'(km1);
    cyc(4);
    chk("R1 reset frame_idx", int'(frame_idx), 0);
    chk("R1 reset cgs_phase", int'(cgs_phase), 1);
    chk("R1 reset misalign", int'(misalign), 0);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic release_at(int p, output int d);
    sync_n = 1'b0;
    cyc(3);
    chk("R5 cgs while low", int'(cgs_phase), 1);
    wait_frame(p);
    sync_n = 1'b1;
    d = 0;
    do begin @(negedge clk); d++; end while (!ila_start && d < 300);
  endtask

  task automatic wait_done(output int d);
    d = 0;
    do begin @(negedge clk); d++; end while (!ila_done && d < 600);
  endtask

  initial begin
    int d, dd, seen;
    do_reset(15);
    // R2 / R3 first edge
    @(negedge clk); #1 sysref = 1'b1;
    @(negedge clk); #1 sysref = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 frame_idx zero after third edge", int'(frame_idx), 0);
    chk("R3 first edge no flag", int'(misalign), 0);
    @(negedge clk);
    chk("R2 count resumes", int'(frame_idx), 1);
    // R3 edge that coincides with wrap
    sysref_pulse_at(13);
    cyc(2);
    chk("R3 on-boundary frame_idx", int'(frame_idx), 0);
    chk("R3 on-boundary no flag", int'(misalign), 0);
    cyc(20);
    chk("R3 still no flag", int'(misalign), 0);

    // R6 / R7 / R8 sweep over every release offset
    for (int p = 0; p < 16; p++) begin
      release_at(p, d);
      chk($sformatf("R6 start delay p=%0d", p), d, 32 - p);
      chk($sformatf("R7 same boundary p=%0d", p), p + d, 32);
      wait_done(dd);
      chk($sformatf("R8 done delay p=%0d", p), dd, 64);
      seen = 0;
      repeat (40) begin @(negedge clk); if (ila_done) seen++; end
      chk("R8 single done pulse", seen, 0);
    end

    // R9 drop during ILA
    release_at(4, d);
    cyc(10);
    sync_n = 1'b0;
    cyc(1);
    chk("R9 cgs after drop in ila", int'(cgs_phase), 1);
    seen = 0;
    repeat (80) begin @(negedge clk); if (ila_done || ila_start) seen++; end
    chk("R9 no pulse while low", seen, 0);
    // R9 drop during hold
    wait_frame(2);
    sync_n = 1'b1;
    cyc(20);
    sync_n = 1'b0;
    seen = 0;
    repeat (60) begin @(negedge clk); if (ila_start) seen++; end
    chk("R9 hold drop suppresses start", seen, 0);
    release_at(9, d);
    chk("R9 new release delay", d, 23);

    // R4 off-boundary edge
    sysref_pulse_at(5);
    cyc(2);
    chk("R4 realigned frame_idx", int'(frame_idx), 0);
    chk("R4 flag set", int'(misalign), 1);
    cyc(50);
    chk("R4 flag sticky", int'(misalign), 1);

    // R10 shorter multiframe
    do_reset(7);
    sysref_pulse_at(3);
    cyc(10);
    release_at(3, d);
    chk("R10 start delay K=8", d, 13);
    wait_done(dd);
    chk("R10 done delay K=8", dd, 32);
    release_at(0, d);
    chk("R10 R7 boundary release K=8", d, 16);
    cyc(5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule